// File: doc/BRIEF.md
# DRAM Software Command Issuer

This block turns one host register write into a single DRAM command on the command and address pins. The command is a mode register set, a refresh, or a precharge. One bit of the mode value decides whether the precharge closes one bank or all banks. The host writes the request in one cycle. The block latches the request and shows it as pending. It drives the command for one cycle to the chosen rank, then keeps NOP on the pins for a configurable number of cycles. After that it clears the pending bit and pulses done.

The block also drives the clock-enable lines of every rank. A two-bit control field in the same write can force all CKE lines low or high. When the field returns to zero, the lines keep the last forced level. They change only when a power-down or self-refresh event input gives them a new level. Refresh scheduling, DRAM timing and the data path belong to other blocks.

Top module: `dram_cmd_issuer`

## Requirements
- R1: After reset, all CKE lines are low, all chip selects are high, RAS/CAS/WE are NOP (111), and pending, done and error are all low.
- R2: A write with only the mode-enable bit set drives RAS/CAS/WE = 000 in the cycle after the write edge. The address bus carries the mode value, the bank address carries the mode-register select, and only the chip select named by the rank field goes low.
- R3: A write with only the set-refresh bit set drives RAS/CAS/WE = 001 in the cycle after the write edge. The address and bank address are zero, whatever the mode value.
- R4: A write with only the set-precharge bit set and mode value bit 5 = 0 drives RAS/CAS/WE = 010 with address line 10 low. The bank address equals the mode-register select and every other address line is zero.
- R5: A precharge write with mode value bit 5 = 1 drives RAS/CAS/WE = 010 with only address line 10 high and the bank address zero (precharge-all).
- R6: After the command cycle, the pins show NOP with all chip selects high for GAP_CYC cycles while pending stays high. In the next cycle done is high for exactly one cycle and pending is low.
- R7: A write with two or more of the three request bits set issues no command and leaves pending low. It raises the error output for one cycle, in the cycle after the write edge.
- R8: Request bits in a write that arrives while pending is high are ignored. Only the first command appears, followed by exactly one done pulse.
- R9: CKE control 01 drives every CKE line low and 10 drives every line high, from the cycle after the write edge. Power events have no effect while either value is held.
- R10: When the control returns to 00, CKE keeps the last forced level. A power event then sets every CKE line to the event's level from the cycle after the event edge.
- R11: The reserved control value 11 forces nothing. It behaves like 00.
- R12: A write with none of the three request bits set issues no command, leaves pending low and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_mode_en | input | 1 | Request: mode register set |
| wr_set_ref | input | 1 | Request: refresh |
| wr_set_pre | input | 1 | Request: precharge |
| wr_rank_sel | input | RANK_SEL_W | Target rank |
| wr_mr_sel | input | BA_W | Mode register / bank select |
| wr_mode_val | input | ADDR_W | Mode value |
| wr_cke_ctl | input | 2 | CKE override: 00 none, 01 low, 10 high, 11 reserved |
| pwr_evt | input | 1 | Power-down / self-refresh entry or exit event |
| pwr_evt_cke | input | 1 | CKE level the event requests |
| req_pending | output | 1 | Request bit, high until the command completes |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle pulse for a conflicting request |
| dram_cs_n | output | NUM_RANKS | Active-low chip selects |
| dram_ba | output | BA_W | Bank address |
| dram_addr | output | ADDR_W | Address bus |
| dram_ras_n | output | 1 | Active-low RAS |
| dram_cas_n | output | 1 | Active-low CAS |
| dram_we_n | output | 1 | Active-low WE |
| dram_cke | output | NUM_RANKS | Clock enable, one per rank |

## Verification
Inputs are driven at falling edges and outputs are sampled at later falling edges. This places every check in a known cycle. The command is due in the first cycle after the write edge. The NOP window covers the next GAP_CYC cycles, and done falls in cycle GAP_CYC + 2. The error pulse and any CKE change from a write or event are due one cycle after their edge. Each check samples in exactly that cycle, and the checks on the cycle after confirm that pulses are one cycle wide.

// File: rtl/dcmd_pkg.sv
// Package: shared types and pin codes for the DRAM software command issuer.
// Assumes active-low RAS/CAS/WE ordered {ras,cas,we}.
package dcmd_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_MRS  = 2'd1,
        KIND_REF  = 2'd2,
        KIND_PRE  = 2'd3
    } cmd_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    localparam logic [2:0] PIN_MRS = 3'b000;
    localparam logic [2:0] PIN_REF = 3'b001;
    localparam logic [2:0] PIN_PRE = 3'b010;
    localparam logic [2:0] PIN_NOP = 3'b111;

    localparam int ALL_BANK_BIT = 5;   // mode value bit choosing precharge-all
    localparam int AUTO_LINE    = 10;  // address line carrying the all-bank flag

    localparam logic [1:0] CKE_FREE = 2'b00;
    localparam logic [1:0] CKE_LOW  = 2'b01;
    localparam logic [1:0] CKE_HIGH = 2'b10;

endpackage

// File: rtl/dcmd_decode.sv
// Request decoder: classifies the three request bits of a write.
// Assumes nothing about timing; purely combinational.
module dcmd_decode
    import dcmd_pkg::*;
(
    input  logic      mode_en,
    input  logic      set_ref,
    input  logic      set_pre,
    output cmd_kind_t kind,
    output logic      conflict
);

    logic [1:0] n_set;

    // count how many request bits are raised
    always_comb begin
        n_set = {1'b0, mode_en} + {1'b0, set_ref} + {1'b0, set_pre};
    end

    // pick the command kind; conflicting or empty writes give KIND_NONE
    always_comb begin
        conflict = (n_set > 2'd1);
        kind     = KIND_NONE;
        if (n_set == 2'd1) begin
            if (mode_en)      kind = KIND_MRS;
            else if (set_ref) kind = KIND_REF;
            else              kind = KIND_PRE;
        end
    end

endmodule

// File: rtl/dcmd_seq.sv
// Sequencer: accepts a request, holds it for one command cycle, counts
// GAP_CYC NOP cycles, then pulses done. Accepts writes only when idle or
// in the done cycle. Assumes GAP_CYC >= 1.
module dcmd_seq
    import dcmd_pkg::*;
#(
    parameter int RANK_SEL_W = 2,
    parameter int BA_W       = 3,
    parameter int ADDR_W     = 16,
    parameter int GAP_CYC    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  cmd_kind_t             wr_kind,
    input  logic                  wr_conflict,
    input  logic [RANK_SEL_W-1:0] wr_rank,
    input  logic [BA_W-1:0]       wr_mr,
    input  logic [ADDR_W-1:0]     wr_val,
    output logic                  issue,
    output cmd_kind_t             lat_kind,
    output logic [RANK_SEL_W-1:0] lat_rank,
    output logic [BA_W-1:0]       lat_mr,
    output logic [ADDR_W-1:0]     lat_val,
    output logic                  pending,
    output logic                  done,
    output logic                  err
);

    localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             open_win, accept;

    // a write can start a command only when no command is in flight
    always_comb begin
        open_win = (state_q == ST_IDLE) || (state_q == ST_DONE);
        accept   = wr_en && open_win && !wr_conflict && (wr_kind != KIND_NONE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (cnt_q == CNT_LAST) state_d = ST_DONE;
            ST_DONE:  state_d = accept ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state, wait counter and error pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            err     <= wr_en && open_win && wr_conflict;
            if (state_q == ST_WAIT) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // latch the accepted request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_kind <= KIND_NONE;
            lat_rank <= '0;
            lat_mr   <= '0;
            lat_val  <= '0;
        end else if (accept) begin
            lat_kind <= wr_kind;
            lat_rank <= wr_rank;
            lat_mr   <= wr_mr;
            lat_val  <= wr_val;
        end
    end

    // status outputs decoded from state
    always_comb begin
        issue   = (state_q == ST_ISSUE);
        pending = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
        done    = (state_q == ST_DONE);
    end

endmodule

// File: rtl/dcmd_pins.sv
// Pin encoder: maps the latched request to chip selects, bank, address
// and RAS/CAS/WE during the issue cycle; NOP with all ranks deselected
// otherwise. Assumes ADDR_W > AUTO_LINE and NUM_RANKS >= 2.
module dcmd_pins
    import dcmd_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int RANK_SEL_W = 2,
    parameter int BA_W       = 3,
    parameter int ADDR_W     = 16
) (
    input  logic                  issue,
    input  cmd_kind_t             kind,
    input  logic [RANK_SEL_W-1:0] rank,
    input  logic [BA_W-1:0]       mr,
    input  logic [ADDR_W-1:0]     val,
    output logic [NUM_RANKS-1:0]  cs_n,
    output logic [BA_W-1:0]       ba,
    output logic [ADDR_W-1:0]     addr,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n
);

    logic       all_bank;
    logic [2:0] code;

    // per-rank chip select: low only for the target rank while issuing
    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cs
        assign cs_n[g] = !(issue && (rank == RANK_SEL_W'(g)));
    end

    // command, bank and address encoding
    always_comb begin
        all_bank = val[ALL_BANK_BIT];
        code     = PIN_NOP;
        ba       = '0;
        addr     = '0;
        if (issue) begin
            case (kind)
                KIND_MRS: begin
                    code = PIN_MRS;
                    ba   = mr;
                    addr = val;
                end
                KIND_REF: code = PIN_REF;
                KIND_PRE: begin
                    code            = PIN_PRE;
                    addr[AUTO_LINE] = all_bank;
                    ba              = all_bank ? '0 : mr;
                end
                default: code = PIN_NOP;
            endcase
        end
        {ras_n, cas_n, we_n} = code;
    end

endmodule

// File: rtl/dcmd_cke.sv
// CKE controller: holds the software override field and the current CKE
// level. A forced level wins; when unforced, the last level persists
// until a power event supplies a new one. Value 11 forces nothing.
module dcmd_cke
    import dcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_ctl,
    input  logic       evt,
    input  logic       evt_level,
    output logic [1:0] ctl_q,
    output logic       level
);

    logic hold_q, forcing, forced_lvl;

    // decode the override field
    always_comb begin
        forcing    = (ctl_q == CKE_LOW) || (ctl_q == CKE_HIGH);
        forced_lvl = (ctl_q == CKE_HIGH);
    end

    // override field register, rewritten on every host write
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= CKE_FREE;
        else if (wr_en) ctl_q <= wr_ctl;
    end

    // held level follows the force, or a power event when unforced
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (forcing) hold_q <= forced_lvl;
        else if (evt)     hold_q <= evt_level;
    end

    // output level
    always_comb begin
        level = forcing ? forced_lvl : hold_q;
    end

endmodule

// File: rtl/dram_cmd_issuer.sv
// Top: software-triggered DRAM command issuer with CKE ownership.
// Assumes NUM_RANKS >= 2, ADDR_W >= 11, GAP_CYC >= 1; host fields are
// valid in the cycle wr_en is high.
module dram_cmd_issuer
    import dcmd_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int BA_W       = 3,
    parameter int ADDR_W     = 16,
    parameter int GAP_CYC    = 3,
    localparam int RANK_SEL_W = $clog2(NUM_RANKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_mode_en,
    input  logic                  wr_set_ref,
    input  logic                  wr_set_pre,
    input  logic [RANK_SEL_W-1:0] wr_rank_sel,
    input  logic [BA_W-1:0]       wr_mr_sel,
    input  logic [ADDR_W-1:0]     wr_mode_val,
    input  logic [1:0]            wr_cke_ctl,
    input  logic                  pwr_evt,
    input  logic                  pwr_evt_cke,
    output logic                  req_pending,
    output logic                  cmd_done,
    output logic                  cmd_err,
    output logic [NUM_RANKS-1:0]  dram_cs_n,
    output logic [BA_W-1:0]       dram_ba,
    output logic [ADDR_W-1:0]     dram_addr,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic [NUM_RANKS-1:0]  dram_cke
);

    cmd_kind_t             dec_kind, lat_kind;
    logic                  dec_conflict, issue, cke_level;
    logic [RANK_SEL_W-1:0] lat_rank;
    logic [BA_W-1:0]       lat_mr;
    logic [ADDR_W-1:0]     lat_val;
    logic [1:0]            cke_ctl_q;

    dcmd_decode u_dec (
        .mode_en  (wr_mode_en),
        .set_ref  (wr_set_ref),
        .set_pre  (wr_set_pre),
        .kind     (dec_kind),
        .conflict (dec_conflict)
    );

    dcmd_seq #(
        .RANK_SEL_W (RANK_SEL_W),
        .BA_W       (BA_W),
        .ADDR_W     (ADDR_W),
        .GAP_CYC    (GAP_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (dec_kind),
        .wr_conflict (dec_conflict),
        .wr_rank     (wr_rank_sel),
        .wr_mr       (wr_mr_sel),
        .wr_val      (wr_mode_val),
        .issue       (issue),
        .lat_kind    (lat_kind),
        .lat_rank    (lat_rank),
        .lat_mr      (lat_mr),
        .lat_val     (lat_val),
        .pending     (req_pending),
        .done        (cmd_done),
        .err         (cmd_err)
    );

    dcmd_pins #(
        .NUM_RANKS  (NUM_RANKS),
        .RANK_SEL_W (RANK_SEL_W),
        .BA_W       (BA_W),
        .ADDR_W     (ADDR_W)
    ) u_pins (
        .issue (issue),
        .kind  (lat_kind),
        .rank  (lat_rank),
        .mr    (lat_mr),
        .val   (lat_val),
        .cs_n  (dram_cs_n),
        .ba    (dram_ba),
        .addr  (dram_addr),
        .ras_n (dram_ras_n),
        .cas_n (dram_cas_n),
        .we_n  (dram_we_n)
    );

    dcmd_cke u_cke (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ctl    (wr_cke_ctl),
        .evt       (pwr_evt),
        .evt_level (pwr_evt_cke),
        .ctl_q     (cke_ctl_q),
        .level     (cke_level)
    );

    // every rank sees the same clock-enable level
    always_comb begin
        dram_cke = {NUM_RANKS{cke_level}};
    end

endmodule

// File: rtl/dcmd_checker.sv
// Checker: temporal properties of the command issuer, bound to the top.
module dcmd_checker #(
    parameter int NUM_RANKS = 4,
    parameter int BA_W      = 3,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 pwr_evt,
    input logic [1:0]           cke_ctl_q,
    input logic                 req_pending,
    input logic                 cmd_done,
    input logic                 cmd_err,
    input logic [NUM_RANKS-1:0] dram_cs_n,
    input logic [BA_W-1:0]      dram_ba,
    input logic [ADDR_W-1:0]    dram_addr,
    input logic                 dram_ras_n,
    input logic                 dram_cas_n,
    input logic                 dram_we_n,
    input logic [NUM_RANKS-1:0] dram_cke
);

    logic [2:0] code;
    assign code = {dram_ras_n, dram_cas_n, dram_we_n};

    // R2: a real command selects exactly one rank
    p_one_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 3'b111) |-> ($countones(~dram_cs_n) == 1));

    // R6: a command occupies a single cycle
    p_cmd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 3'b111) |=> (code == 3'b111));

    // R6: NOP deselects every rank
    p_nop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b111) |-> (&dram_cs_n));

    // R6: done lasts one cycle and coincides with pending low
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !req_pending);

    // R7: an error never accompanies a pending command
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!req_pending && code == 3'b111));

    // R5: precharge-all drives bank address zero
    p_all_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b010 && dram_addr[10]) |-> (dram_ba == '0));

    // R9: forced levels reach every CKE line
    p_force_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_ctl_q == 2'b01) |-> (dram_cke == '0));
    p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_ctl_q == 2'b10) |-> (&dram_cke));

    // R10: without force, write or event, CKE holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_ctl_q == 2'b00 && !wr_en && !pwr_evt) |=> $stable(dram_cke));

endmodule

bind dram_cmd_issuer dcmd_checker #(
    .NUM_RANKS (NUM_RANKS),
    .BA_W      (BA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .pwr_evt     (pwr_evt),
    .cke_ctl_q   (cke_ctl_q),
    .req_pending (req_pending),
    .cmd_done    (cmd_done),
    .cmd_err     (cmd_err),
    .dram_cs_n   (dram_cs_n),
    .dram_ba     (dram_ba),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_cke    (dram_cke)
);

// File: tb/tb_dram_cmd_issuer.sv
`timescale 1ns/1ps
// Bench: vector table for the command kinds, then directed tests.
module tb_dram_cmd_issuer;

    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_mode_en = 1'b0, wr_set_ref = 1'b0, wr_set_pre = 1'b0;
    logic [1:0]  wr_rank_sel = '0;
    logic [2:0]  wr_mr_sel = '0;
    logic [15:0] wr_mode_val = '0;
    logic [1:0]  wr_cke_ctl = '0;
    logic        pwr_evt = 1'b0, pwr_evt_cke = 1'b0;
    logic        req_pending, cmd_done, cmd_err;
    logic [3:0]  dram_cs_n, dram_cke;
    logic [2:0]  dram_ba;
    logic [15:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    dram_cmd_issuer #(.NUM_RANKS(4), .BA_W(3), .ADDR_W(16), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode_en(wr_mode_en),
        .wr_set_ref(wr_set_ref), .wr_set_pre(wr_set_pre), .wr_rank_sel(wr_rank_sel),
        .wr_mr_sel(wr_mr_sel), .wr_mode_val(wr_mode_val), .wr_cke_ctl(wr_cke_ctl),
        .pwr_evt(pwr_evt), .pwr_evt_cke(pwr_evt_cke), .req_pending(req_pending),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .dram_cs_n(dram_cs_n), .dram_ba(dram_ba),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_cke(dram_cke)
    );

    typedef struct packed {
        logic        me, sr, sp;
        logic [1:0]  rank;
        logic [2:0]  mr;
        logic [15:0] val;
        logic [2:0]  cmd;
        logic [15:0] addr;
        logic [2:0]  ba;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 3'd2, 16'h0532, 3'b000, 16'h0532, 3'd2},  // R2
        '{1'b1, 1'b0, 1'b0, 2'd3, 3'd7, 16'hFFFF, 3'b000, 16'hFFFF, 3'd7},  // R2
        '{1'b0, 1'b1, 1'b0, 2'd1, 3'd5, 16'hABCD, 3'b001, 16'h0000, 3'd0},  // R3
        '{1'b0, 1'b0, 1'b1, 2'd2, 3'd4, 16'h0000, 3'b010, 16'h0000, 3'd4},  // R4
        '{1'b0, 1'b0, 1'b1, 2'd1, 3'd6, 16'hFFDF, 3'b010, 16'h0000, 3'd6},  // R4
        '{1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 16'h0020, 3'b010, 16'h0400, 3'd0},  // R5
        '{1'b0, 1'b0, 1'b1, 2'd3, 3'd1, 16'hFFFF, 3'b010, 16'h0400, 3'd0}   // R5
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] pins();
        return {dram_ras_n, dram_cas_n, dram_we_n};
    endfunction

    // drive one host write at a falling edge; returns at the next falling edge
    task automatic host_write(input logic me, input logic sr, input logic sp,
                              input logic [1:0] rank, input logic [2:0] mr,
                              input logic [15:0] val, input logic [1:0] ctl);
        wr_mode_en = me; wr_set_ref = sr; wr_set_pre = sp;
        wr_rank_sel = rank; wr_mr_sel = mr; wr_mode_val = val; wr_cke_ctl = ctl;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_mode_en = 1'b0; wr_set_ref = 1'b0; wr_set_pre = 1'b0;
    endtask

    task automatic power_event(input logic lvl);
        pwr_evt = 1'b1; pwr_evt_cke = lvl;
        @(negedge clk);
        pwr_evt = 1'b0;
    endtask

    task automatic idle_nop(input string req);
        chk(pins() == 3'b111 && dram_cs_n == 4'hF, req, {25'd0, pins(), dram_cs_n}, 32'h7F);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(dram_cke == 4'h0, "R1 cke", dram_cke, 0);
        idle_nop("R1 pins");
        chk(!req_pending && !cmd_done && !cmd_err, "R1 status",
            {req_pending, cmd_done, cmd_err}, 0);

        // R2..R6 table walk
        for (int i = 0; i < 7; i++) begin
            vec_t v = VECS[i];
            host_write(v.me, v.sr, v.sp, v.rank, v.mr, v.val, 2'b00);
            chk(pins() == v.cmd, "R2-R5 code", pins(), v.cmd);
            chk(dram_addr == v.addr, "R2-R5 addr", dram_addr, v.addr);
            chk(dram_ba == v.ba, "R2-R5 ba", dram_ba, v.ba);
            chk(dram_cs_n == ~(4'b1 << v.rank), "R2 rank", dram_cs_n, ~(4'b1 << v.rank));
            chk(req_pending && !cmd_done, "R6 issue pending", req_pending, 1);
            for (int k = 0; k < GAP; k++) begin
                @(negedge clk);
                idle_nop("R6 gap nop");
                chk(req_pending && !cmd_done, "R6 gap pending", req_pending, 1);
            end
            @(negedge clk);
            chk(cmd_done && !req_pending, "R6 done", {cmd_done, req_pending}, 2'b10);
            @(negedge clk);
            chk(!cmd_done, "R6 done width", cmd_done, 0);
        end

        // R7 conflicting request bits
        host_write(1'b1, 1'b1, 1'b0, 2'd1, 3'd1, 16'h1234, 2'b00);
        chk(cmd_err && !req_pending, "R7 err", {cmd_err, req_pending}, 2'b10);
        idle_nop("R7 no cmd");
        @(negedge clk);
        chk(!cmd_err && !req_pending, "R7 err width", {cmd_err, req_pending}, 0);
        host_write(1'b1, 1'b1, 1'b1, 2'd2, 3'd0, 16'h0, 2'b00);
        chk(cmd_err, "R7 err triple", cmd_err, 1);
        @(negedge clk);

        // R12 empty request
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'hFFFF, 2'b00);
        chk(!cmd_err && !req_pending, "R12 empty", {cmd_err, req_pending}, 0);
        idle_nop("R12 no cmd");

        // R8 write while pending is ignored
        host_write(1'b0, 1'b1, 1'b0, 2'd2, 3'd0, 16'h0, 2'b00);
        chk(pins() == 3'b001, "R8 first cmd", pins(), 3'b001);
        begin
            int dones = 0;
            host_write(1'b1, 1'b0, 1'b0, 2'd0, 3'd5, 16'h5555, 2'b00);
            for (int k = 0; k < GAP + 4; k++) begin
                idle_nop("R8 no second cmd");
                if (cmd_done) dones++;
                @(negedge clk);
            end
            chk(dones == 1, "R8 one done", dones, 1);
            chk(!req_pending, "R8 settled", req_pending, 0);
        end

        // R9 forcing and events ignored while forced
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0, 2'b10);
        chk(dram_cke == 4'hF, "R9 force high", dram_cke, 4'hF);
        power_event(1'b0);
        chk(dram_cke == 4'hF, "R9 event ignored high", dram_cke, 4'hF);
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0, 2'b01);
        chk(dram_cke == 4'h0, "R9 force low", dram_cke, 0);
        power_event(1'b1);
        chk(dram_cke == 4'h0, "R9 event ignored low", dram_cke, 0);

        // R10 release keeps level until an event
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0, 2'b10);
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0, 2'b00);
        repeat (3) @(negedge clk);
        chk(dram_cke == 4'hF, "R10 hold after release", dram_cke, 4'hF);
        power_event(1'b0);
        chk(dram_cke == 4'h0, "R10 event low", dram_cke, 0);
        power_event(1'b1);
        chk(dram_cke == 4'hF, "R10 event high", dram_cke, 4'hF);

        // R11 reserved code forces nothing
        host_write(1'b0, 1'b0, 1'b0, 2'd0, 3'd0, 16'h0, 2'b11);
        chk(dram_cke == 4'hF, "R11 no force", dram_cke, 4'hF);
        power_event(1'b0);
        chk(dram_cke == 4'h0, "R11 event applies", dram_cke, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule